// File: doc/BRIEF.md
# Raster Sync and Blank Generator

This block derives the raster timing of a display of about 640 by 480 pixels from a pixel clock. A horizontal position counter steps on every clock and wraps at a programmed last count. A vertical line counter steps once per line and wraps at its own last line. Fixed window decoders compare each counter against constants to produce the horizontal blank, vertical blank and sync windows. The decode that marks each counter's last value also returns that counter to zero.

The outputs are horizontal blank, vertical blank, a separate vertical sync and one combined sync line. The combined line carries the horizontal sync exclusive-ORed with the vertical sync. The default thresholds give a 632-pixel active line of 889 clocks and a 480-line active frame of 525 lines. These are deliberately not the common industry timing. Every threshold, the counter width and the sync polarity are elaboration parameters. Parameter sets whose windows are out of order are rejected at elaboration. A user places the block next to a pixel pipeline and uses the blanks to gate pixel output.

Top module: `raster_timing_gen`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, both counters return to zero. After that edge `h_blank` and `v_blank` are 0, and `v_sync` and `c_sync` sit at their inactive level.
- R2: The horizontal counter cycles through 0 to `H_LAST` (default 888), giving a line of 889 clocks. `h_blank` is 1 for counts `H_BLANK_START` (default 632) through `H_LAST`.
- R3: The internal horizontal sync is active for counts `H_SYNC_START` (default 696) up to but not including `H_SYNC_END` (default 760). It is seen at `c_sync` outside vertical sync lines.
- R4: The line counter advances only when the horizontal counter wraps from `H_LAST` to 0, and it cycles 0 to `V_LAST` (default 524). `v_blank` is 1 for lines `V_BLANK_START` (default 480) through `V_LAST`.
- R5: `v_sync` is active for whole lines from `V_SYNC_START` (default 483) up to but not including `V_SYNC_END` (default 486). Those lines lie inside vertical blank.
- R6: `c_sync` equals horizontal sync XOR vertical sync. During vertical sync lines it is the inverse of horizontal sync, and outside horizontal blank it equals `v_sync`.
- R7: All four outputs are registered and aligned with the counters. After k clock edges with reset low, the outputs show the decode of horizontal count k mod (`H_LAST`+1) and line (k div (`H_LAST`+1)) mod (`V_LAST`+1).
- R8: With `SYNC_ACTIVE_HIGH` = 0, `v_sync` and `c_sync` are inverted, including their reset level. `h_blank` and `v_blank` stay active high.
- R9: The thresholds and width are parameters: scaled values give the same window shapes. Parameters are rejected at elaboration if the windows are out of order or a last count does not fit `CNT_W` bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| h_blank | output | 1 | Horizontal blank, active high |
| v_blank | output | 1 | Vertical blank, active high |
| v_sync | output | 1 | Vertical sync, polarity set by `SYNC_ACTIVE_HIGH` |
| c_sync | output | 1 | Horizontal sync XOR vertical sync, polarity set by `SYNC_ACTIVE_HIGH` |

## Verification
The in-line assertions check these every cycle:
- each counter stays within its last count and returns to zero after it;
- the line counter holds except at a horizontal wrap;
- vertical sync never shows outside vertical blank;
- the combined sync follows vertical sync wherever horizontal blank is low.

The exact window edges, line and frame lengths, the behaviour of the inverted-polarity variant and recovery from a reset in mid-frame can only be shown by the bench. It compares every output against a model of the cycle count, using shortened-frame instances plus the default instance over its first lines.

// File: rtl/raster_pkg.sv
package raster_pkg;

   // Decoded window state for one raster position, before polarity
   typedef struct packed {
      logic h_blank;
      logic v_blank;
      logic h_sync;
      logic v_sync;
   } raster_flags_t;

   function automatic bit window_order_ok(int blank_start, int sync_start,
                                          int sync_end, int last);
      return (blank_start > 0) && (blank_start <= sync_start) &&
             (sync_start < sync_end) && (sync_end <= last + 1);
   endfunction

endpackage

// File: rtl/raster_counter.sv
module raster_counter #(
   parameter int CNT_W = 10,
   parameter int LAST  = 888
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             adv,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cnt_nxt,
   output logic             at_last
);

   localparam logic [CNT_W-1:0] LAST_C = CNT_W'(LAST);
   localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

   assign at_last = (cnt == LAST_C);

   always_comb begin
      cnt_nxt = cnt;
      if (adv) begin
         if (at_last) cnt_nxt = '0;
         else         cnt_nxt = cnt + ONE_C;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) cnt <= '0;
      else     cnt <= cnt_nxt;
   end

   // R2 / R4: counter never passes its last value
   a_r2_count_bounded: assert property (@(posedge clk) disable iff (rst)
      cnt <= LAST_C);

   // R2 / R4: an advancing counter at its last value returns to zero
   a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
      (adv && cnt == LAST_C) |=> (cnt == '0));

   // R4: an idle counter holds its value
   a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(cnt));

endmodule

// File: rtl/raster_window.sv
module raster_window #(
   parameter int CNT_W = 10,
   parameter int START = 632,
   parameter int STOP  = 889,
   parameter int LAST  = 888
) (
   input  logic [CNT_W-1:0] val,
   output logic             active
);

   localparam logic [CNT_W-1:0] START_C = CNT_W'(START);

   generate
      if (STOP > LAST) begin : g_open_end
         // window runs to the last count: upper compare is redundant
         assign active = (val >= START_C);
      end else begin : g_closed
         localparam logic [CNT_W-1:0] STOP_C = CNT_W'(STOP);
         assign active = (val >= START_C) && (val < STOP_C);
      end
   endgenerate

endmodule

// File: rtl/raster_outputs.sv
module raster_outputs
   import raster_pkg::*;
#(
   parameter bit SYNC_ACTIVE_HIGH = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  raster_flags_t flags_nxt,
   output logic          h_blank,
   output logic          v_blank,
   output logic          v_sync,
   output logic          c_sync
);

   logic inv;

   generate
      if (SYNC_ACTIVE_HIGH) begin : g_pol_high
         assign inv = 1'b0;
      end else begin : g_pol_low
         assign inv = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         h_blank <= 1'b0;
         v_blank <= 1'b0;
         v_sync  <= inv;
         c_sync  <= inv;
      end else begin
         h_blank <= flags_nxt.h_blank;
         v_blank <= flags_nxt.v_blank;
         v_sync  <= flags_nxt.v_sync ^ inv;
         c_sync  <= (flags_nxt.h_sync ^ flags_nxt.v_sync) ^ inv;
      end
   end

   // R5: vertical sync only inside vertical blank
   a_r5_vsync_in_vblank: assert property (@(posedge clk) disable iff (rst)
      (v_sync != inv) |-> v_blank);

   // R6: outside horizontal blank the combined line follows vertical sync
   a_r6_csync_tracks_vsync: assert property (@(posedge clk) disable iff (rst)
      !h_blank |-> (c_sync == v_sync));

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
   import raster_pkg::*;
#(
   parameter int CNT_W            = 10,
   parameter int H_BLANK_START    = 632,
   parameter int H_SYNC_START     = 696,
   parameter int H_SYNC_END       = 760,
   parameter int H_LAST           = 888,
   parameter int V_BLANK_START    = 480,
   parameter int V_SYNC_START     = 483,
   parameter int V_SYNC_END       = 486,
   parameter int V_LAST           = 524,
   parameter bit SYNC_ACTIVE_HIGH = 1'b1
) (
   input  logic clk,
   input  logic rst,
   output logic h_blank,
   output logic v_blank,
   output logic v_sync,
   output logic c_sync
);

   localparam int CNT_SPAN = 1 << CNT_W;
   localparam logic [CNT_W-1:0] H_LAST_C = CNT_W'(H_LAST);

   // R9: elaboration-time parameter checks
   generate
      if (H_LAST >= CNT_SPAN || V_LAST >= CNT_SPAN) begin : g_bad_width
         $error("raster_timing_gen: last count does not fit CNT_W");
      end
      if (!window_order_ok(H_BLANK_START, H_SYNC_START, H_SYNC_END, H_LAST))
      begin : g_bad_h
         $error("raster_timing_gen: horizontal windows out of order");
      end
      if (!window_order_ok(V_BLANK_START, V_SYNC_START, V_SYNC_END, V_LAST))
      begin : g_bad_v
         $error("raster_timing_gen: vertical windows out of order");
      end
   endgenerate

   logic [CNT_W-1:0] h_cnt, h_nxt, v_cnt, v_nxt;
   logic             h_at_last, v_at_last;
   raster_flags_t    flags_nxt;

   raster_counter #(.CNT_W(CNT_W), .LAST(H_LAST)) u_hcnt (
      .clk(clk), .rst(rst), .adv(1'b1),
      .cnt(h_cnt), .cnt_nxt(h_nxt), .at_last(h_at_last));

   raster_counter #(.CNT_W(CNT_W), .LAST(V_LAST)) u_vcnt (
      .clk(clk), .rst(rst), .adv(h_at_last),
      .cnt(v_cnt), .cnt_nxt(v_nxt), .at_last(v_at_last));

   // decode on next-state values so registered outputs line up with counters
   raster_window #(.CNT_W(CNT_W), .START(H_BLANK_START), .STOP(H_LAST + 1),
                   .LAST(H_LAST)) u_hblank (.val(h_nxt), .active(flags_nxt.h_blank));
   raster_window #(.CNT_W(CNT_W), .START(H_SYNC_START), .STOP(H_SYNC_END),
                   .LAST(H_LAST)) u_hsync (.val(h_nxt), .active(flags_nxt.h_sync));
   raster_window #(.CNT_W(CNT_W), .START(V_BLANK_START), .STOP(V_LAST + 1),
                   .LAST(V_LAST)) u_vblank (.val(v_nxt), .active(flags_nxt.v_blank));
   raster_window #(.CNT_W(CNT_W), .START(V_SYNC_START), .STOP(V_SYNC_END),
                   .LAST(V_LAST)) u_vsync (.val(v_nxt), .active(flags_nxt.v_sync));

   raster_outputs #(.SYNC_ACTIVE_HIGH(SYNC_ACTIVE_HIGH)) u_out (
      .clk(clk), .rst(rst), .flags_nxt(flags_nxt),
      .h_blank(h_blank), .v_blank(v_blank), .v_sync(v_sync), .c_sync(c_sync));

   // R4: line counter moves only on a horizontal wrap
   a_r4_line_steps_on_wrap: assert property (@(posedge clk) disable iff (rst)
      (h_cnt != H_LAST_C) |=> $stable(v_cnt));

   // R4: at the last line and last count the frame restarts at line zero
   a_r4_frame_restart: assert property (@(posedge clk) disable iff (rst)
      (h_at_last && v_at_last) |=> (v_cnt == '0 && h_cnt == '0));

endmodule

// File: tb/raster_timing_gen_tb.sv
module raster_timing_gen_tb;

   localparam int SB = 40, SS = 45, SE = 50, SL = 59;   // scaled horizontal
   localparam int VB = 30, VS = 33, VE = 36, VL = 39;   // scaled vertical

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #10 clk = ~clk;

   logic hb_s, vb_s, vs_s, cs_s;
   logic hb_l, vb_l, vs_l, cs_l;
   logic hb_d, vb_d, vs_d, cs_d;

   raster_timing_gen #(.H_BLANK_START(SB), .H_SYNC_START(SS), .H_SYNC_END(SE),
      .H_LAST(SL), .V_BLANK_START(VB), .V_SYNC_START(VS), .V_SYNC_END(VE),
      .V_LAST(VL)) u_dut (
      .clk(clk), .rst(rst), .h_blank(hb_s), .v_blank(vb_s), .v_sync(vs_s), .c_sync(cs_s));

   raster_timing_gen #(.H_BLANK_START(SB), .H_SYNC_START(SS), .H_SYNC_END(SE),
      .H_LAST(SL), .V_BLANK_START(VB), .V_SYNC_START(VS), .V_SYNC_END(VE),
      .V_LAST(VL), .SYNC_ACTIVE_HIGH(1'b0)) u_dut_lo (
      .clk(clk), .rst(rst), .h_blank(hb_l), .v_blank(vb_l), .v_sync(vs_l), .c_sync(cs_l));

   raster_timing_gen u_dut_def (
      .clk(clk), .rst(rst), .h_blank(hb_d), .v_blank(vb_d), .v_sync(vs_d), .c_sync(cs_d));

   int tests = 0;
   int fails = 0;
   int k = 0;
   bit done = 1'b0;

   function automatic logic [3:0] model(int kk, int hb, int hs, int he, int hl,
                                        int vb, int vs, int ve, int vl, bit ah);
      int h, v;
      logic hbl, vbl, hsy, vsy, inv;
      h   = kk % (hl + 1);
      v   = (kk / (hl + 1)) % (vl + 1);
      hbl = (h >= hb);
      vbl = (v >= vb);
      hsy = (h >= hs) && (h < he);
      vsy = (v >= vs) && (v < ve);
      inv = !ah;
      return {hbl, vbl, vsy ^ inv, (hsy ^ vsy) ^ inv};
   endfunction

   task automatic chk(string req, logic got, logic exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s k=%0d got=%b exp=%b", req, k, got, exp);
      end
   endtask

   task automatic chk_int(string req, int got, int exp);
      tests++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s got=%0d exp=%0d", req, got, exp);
      end
   endtask

   task automatic step(logic r);
      rst = r;
      @(posedge clk);
      if (r) k = 0;
      else   k++;
      @(negedge clk);
   endtask

   task automatic check_all();
      logic [3:0] e;
      e = model(k, SB, SS, SE, SL, VB, VS, VE, VL, 1'b1);
      chk("R2 h_blank", hb_s, e[3]);
      chk("R4 v_blank", vb_s, e[2]);
      chk("R5 v_sync", vs_s, e[1]);
      chk("R3 R6 c_sync", cs_s, e[0]);
      e = model(k, SB, SS, SE, SL, VB, VS, VE, VL, 1'b0);
      chk("R8 h_blank", hb_l, e[3]);
      chk("R8 v_blank", vb_l, e[2]);
      chk("R8 v_sync", vs_l, e[1]);
      chk("R8 c_sync", cs_l, e[0]);
      e = model(k, 632, 696, 760, 888, 480, 483, 486, 524, 1'b1);
      chk("R7 default h_blank", hb_d, e[3]);
      chk("R7 default v_blank", vb_d, e[2]);
      chk("R7 default v_sync", vs_d, e[1]);
      chk("R7 default c_sync", cs_d, e[0]);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin : stim
      int hb_rise, vs_rise, cs_edges;
      logic hb_prev, vs_prev, cs_prev;
      void'($urandom(32'd7331));
      @(negedge clk);
      repeat (3) step(1'b1);
      // R1: reset state of all instances
      chk("R1 h_blank", hb_s, 1'b0);
      chk("R1 v_blank", vb_s, 1'b0);
      chk("R1 v_sync", vs_s, 1'b0);
      chk("R1 c_sync", cs_s, 1'b0);
      chk("R1 R8 v_sync low-pol", vs_l, 1'b1);
      chk("R1 R8 c_sync low-pol", cs_l, 1'b1);
      check_all();

      // two full scaled frames, R9 scaled parameters, plus edge counts
      hb_rise = 0; vs_rise = 0; cs_edges = 0;
      hb_prev = hb_s; vs_prev = vs_s; cs_prev = cs_s;
      for (int i = 0; i < 2 * (SL + 1) * (VL + 1); i++) begin
         step(1'b0);
         check_all();
         if (hb_s && !hb_prev) hb_rise++;
         if (vs_s && !vs_prev) vs_rise++;
         if (cs_s != cs_prev) cs_edges++;
         hb_prev = hb_s; vs_prev = vs_s; cs_prev = cs_s;
      end
      chk_int("R2 R9 h_blank rises in two frames", hb_rise, 2 * (VL + 1));
      chk_int("R5 R9 v_sync rises in two frames", vs_rise, 2);
      // each line: two hsync edges; each vsync pulse adds entry and exit edges
      chk_int("R6 c_sync edges in two frames", cs_edges, 2 * 2 * (VL + 1) + 2 * 2);

      // random run lengths with mid-frame resets
      for (int n = 0; n < 6; n++) begin
         int run, hold;
         run  = 50 + int'($urandom % 3000);
         hold = 1 + int'($urandom % 3);
         repeat (run) begin
            step(1'b0);
            check_all();
         end
         repeat (hold) step(1'b1);
         chk("R1 h_blank after mid reset", hb_s, 1'b0);
         chk("R1 c_sync after mid reset", cs_s, 1'b0);
         check_all();
      end

      // directed: cross the default line boundary of the full-size instance
      repeat (900) begin
         step(1'b0);
         check_all();
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule